// File: doc/BRIEF.md
# Interlocked Pipeline Stall Controller

This block sequences the control side of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that has no forwarding network. It keeps the decode-stage register fields (a valid bit, two source register numbers and one destination register number). It also carries a destination tag and a valid bit through the execute, memory and writeback stages. From these it decides every cycle whether the instruction in decode must wait for an older instruction that still has to write one of its sources.

When a read-after-write conflict exists, the block pulls its active-low stall output low and raises a hold enable for the upstream fetch register. It keeps its own decode register unchanged and sends an empty slot (a bubble) into execute in place of the waiting instruction. The later stages keep advancing, so the blocking instruction drains out. The stall clears once that instruction has left writeback. A consumer placed directly behind its producer therefore waits three cycles. The datapath, the memories and the register file values are not modelled.

Top module: `ilk_stall_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the decode valid bit and every stage valid bit, and sets every stage destination tag to 0. On the first cycle after reset, stall_n is 1.
- R2: stall_n is 0, and fetch_hold is 1, exactly when the decode slot is valid and one of its two source numbers is nonzero and equals the destination tag of a valid execute, memory or writeback stage. Otherwise stall_n is 1 and fetch_hold is 0.
- R3: Register number 0 never causes a stall, whether it is a source of the decode instruction or the destination of an older instruction. Instructions that write no register carry destination 0.
- R4: While stalled, the decode register ignores the fetch inputs. After release, the held instruction, not a later fetch value, is the one that enters execute.
- R5: Each stalled cycle places a bubble in execute on the next cycle: valid 0 and destination 0.
- R6: The memory stage takes the previous cycle's execute tag and valid bit, and the writeback stage takes the previous cycle's memory values, on every cycle, stalled or not.
- R7: A consumer fetched directly after the producer of one of its sources is stalled for exactly three cycles before it enters execute.
- R8: A consumer fetched 2, 3 or 4 instructions after its producer is stalled for 2, 1 or 0 cycles respectively.
- R9: The stall output never stays low for more than three consecutive cycles.
- R10: An empty decode slot (fetch_vld 0) never stalls, whatever its source numbers are. It enters execute with valid 0 and destination 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | Fetch slot holds an instruction |
| fetch_src_a | input | 3 | First source register number from fetch |
| fetch_src_b | input | 3 | Second source register number from fetch |
| fetch_dst | input | 3 | Destination register number from fetch (0 = writes nothing) |
| stall_n | output | 1 | Active-low stall |
| fetch_hold | output | 1 | Hold enable for the upstream fetch register |
| stage_vld | output | 3 | Valid bits; bit 0 execute, bit 1 memory, bit 2 writeback |
| stage_dst | output | 9 | Destination tags; [2:0] execute, [5:3] memory, [8:6] writeback |

## Verification
The assertions assume that the fetch side honours fetch_hold. Whatever is presented while fetch_hold is high is expected to be dropped, not recorded as issued. The bench's issue task keeps an instruction on the fetch inputs until a cycle ends with fetch_hold low. In one directed case it deliberately scrambles those inputs while held, to show they are dropped. The random phase draws register numbers from the full eight-entry space with a high share of valid slots, so overlapping producer and consumer tags occur often.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  localparam int REG_W_DEF = 3;   // register number width
  localparam int DEPTH_DEF = 3;   // compared later stages: execute, memory, writeback
  localparam int NSRC      = 2;   // source operands per instruction
endpackage

// File: rtl/ilk_decode_reg.sv
module ilk_decode_reg #(
  parameter int REG_W = ilk_pkg::REG_W_DEF,
  parameter int NSRC  = ilk_pkg::NSRC
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  logic                        in_vld,
  input  logic [NSRC-1:0][REG_W-1:0]  in_src,
  input  logic [REG_W-1:0]            in_dst,
  output logic                        out_vld,
  output logic [NSRC-1:0][REG_W-1:0]  out_src,
  output logic [REG_W-1:0]            out_dst
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_src <= '0;
      out_dst <= '0;
    end else if (!hold) begin
      out_vld <= in_vld;
      out_src <= in_src;
      out_dst <= in_dst;
    end
  end

  // R4: a held decode slot keeps its fields
  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(out_vld) && $stable(out_src) && $stable(out_dst)));

endmodule

// File: rtl/ilk_tag_pipe.sv
module ilk_tag_pipe #(
  parameter int REG_W = ilk_pkg::REG_W_DEF,
  parameter int DEPTH = ilk_pkg::DEPTH_DEF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stall,
  input  logic                         dec_vld,
  input  logic [REG_W-1:0]             dec_dst,
  output logic [DEPTH-1:0]             stg_vld,
  output logic [DEPTH-1:0][REG_W-1:0]  stg_dst
);

  logic             head_vld;
  logic [REG_W-1:0] head_dst;

  // bubble on stall; an empty slot also carries tag 0
  always_comb begin
    head_vld = dec_vld && !stall;
    head_dst = head_vld ? dec_dst : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_vld[0] <= 1'b0;
      stg_dst[0] <= '0;
    end else begin
      stg_vld[0] <= head_vld;
      stg_dst[0] <= head_dst;
    end
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_vld[i] <= 1'b0;
        stg_dst[i] <= '0;
      end else begin
        stg_vld[i] <= stg_vld[i-1];
        stg_dst[i] <= stg_dst[i-1];
      end
    end

    // R6: later stages advance every cycle, stall or not
    assert_stage_advance_R6: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (stg_vld[i] == $past(stg_vld[i-1]) && stg_dst[i] == $past(stg_dst[i-1])));
  end

  // R5: a stalled cycle leaves a bubble in execute
  assert_bubble_R5: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!stg_vld[0] && stg_dst[0] == '0));

  // R1: reset empties every stage
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stg_vld == '0 && stg_dst == '0));

endmodule

// File: rtl/ilk_hazard_cmp.sv
module ilk_hazard_cmp #(
  parameter int REG_W = ilk_pkg::REG_W_DEF,
  parameter int DEPTH = ilk_pkg::DEPTH_DEF,
  parameter int NSRC  = ilk_pkg::NSRC
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dec_vld,
  input  logic [NSRC-1:0][REG_W-1:0]   dec_src,
  input  logic [DEPTH-1:0]             stg_vld,
  input  logic [DEPTH-1:0][REG_W-1:0]  stg_dst,
  output logic                         hazard
);

  localparam int NCMP = NSRC * DEPTH;

  logic [NCMP-1:0] hit;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar k = 0; k < DEPTH; k++) begin : g_stg
      assign hit[s*DEPTH+k] = (dec_src[s] != '0) && stg_vld[k] && (stg_dst[k] == dec_src[s]);
    end
  end

  assign hazard = dec_vld && (|hit);

  // R3: sources that are all register 0 never stall
  assert_zero_src_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_src == '0) |-> !hazard);

  // R10: an empty decode slot never stalls
  assert_empty_slot_R10: assert property (@(posedge clk) disable iff (rst)
    !dec_vld |-> !hazard);

endmodule

// File: rtl/ilk_stall_ctrl.sv
module ilk_stall_ctrl #(
  parameter int REG_W = ilk_pkg::REG_W_DEF,
  parameter int DEPTH = ilk_pkg::DEPTH_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fetch_vld,
  input  logic [REG_W-1:0]        fetch_src_a,
  input  logic [REG_W-1:0]        fetch_src_b,
  input  logic [REG_W-1:0]        fetch_dst,
  output logic                    stall_n,
  output logic                    fetch_hold,
  output logic [DEPTH-1:0]        stage_vld,
  output logic [DEPTH*REG_W-1:0]  stage_dst
);

  localparam int NSRC  = ilk_pkg::NSRC;
  localparam int CNT_W = $clog2(DEPTH + 1) + 1;

  logic                         stall;
  logic                         dec_vld;
  logic [NSRC-1:0][REG_W-1:0]   dec_src;
  logic [REG_W-1:0]             dec_dst;
  logic [DEPTH-1:0]             stg_vld;
  logic [DEPTH-1:0][REG_W-1:0]  stg_dst;

  ilk_decode_reg #(.REG_W(REG_W), .NSRC(NSRC)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .hold    (stall),
    .in_vld  (fetch_vld),
    .in_src  ({fetch_src_b, fetch_src_a}),
    .in_dst  (fetch_dst),
    .out_vld (dec_vld),
    .out_src (dec_src),
    .out_dst (dec_dst)
  );

  ilk_hazard_cmp #(.REG_W(REG_W), .DEPTH(DEPTH), .NSRC(NSRC)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .dec_vld (dec_vld),
    .dec_src (dec_src),
    .stg_vld (stg_vld),
    .stg_dst (stg_dst),
    .hazard  (stall)
  );

  ilk_tag_pipe #(.REG_W(REG_W), .DEPTH(DEPTH)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall),
    .dec_vld (dec_vld),
    .dec_dst (dec_dst),
    .stg_vld (stg_vld),
    .stg_dst (stg_dst)
  );

  assign stall_n    = ~stall;
  assign fetch_hold = stall;
  assign stage_vld  = stg_vld;
  assign stage_dst  = stg_dst;

  // length of the current run of stalled cycles, for the bound check
  logic [CNT_W-1:0] run_cnt;
  always_ff @(posedge clk) begin
    if (rst)        run_cnt <= '0;
    else if (stall) run_cnt <= run_cnt + 1'b1;
    else            run_cnt <= '0;
  end

  // R9: no stall run is longer than the number of compared stages
  assert_stall_bound_R9: assert property (@(posedge clk) disable iff (rst)
    !stall_n |-> (run_cnt < CNT_W'(DEPTH)));

  // R2: hold enable and stall are always complementary
  assert_hold_pairs_R2: assert property (@(posedge clk) disable iff (rst)
    fetch_hold != stall_n);

endmodule

// File: tb/test_ilk_stall_ctrl.sv
`timescale 1ns/1ps
module test_ilk_stall_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic       fetch_vld;
  logic [2:0] fetch_src_a, fetch_src_b, fetch_dst;
  logic       stall_n, fetch_hold;
  logic [2:0] stage_vld;
  logic [8:0] stage_dst;

  always #2 clk = ~clk;  // 250 MHz

  ilk_stall_ctrl i_ilk_stall_ctrl (
    .clk(clk), .rst(rst), .fetch_vld(fetch_vld),
    .fetch_src_a(fetch_src_a), .fetch_src_b(fetch_src_b), .fetch_dst(fetch_dst),
    .stall_n(stall_n), .fetch_hold(fetch_hold),
    .stage_vld(stage_vld), .stage_dst(stage_dst)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench reference state
  bit       m_dv;
  bit [2:0] m_da, m_db, m_dd;
  bit       m_sv [3];
  bit [2:0] m_sd [3];
  int       run_len = 0, max_run = 0;

  function automatic bit src_hit(bit [2:0] s);
    for (int k = 0; k < 3; k++)
      if (s != 0 && m_sv[k] && m_sd[k] == s) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit exp_stall();
    return m_dv && (src_hit(m_da) || src_hit(m_db));
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: compare outputs, then advance the reference at the edge
  task automatic tick();
    bit e;
    e = exp_stall();
    chk(stall_n === ~e && fetch_hold === e, "R2 R3 R10 stall/hold", {30'd0, stall_n, fetch_hold}, {30'd0, ~e, e});
    for (int k = 0; k < 3; k++)
      chk(stage_vld[k] === m_sv[k] && stage_dst[k*3+:3] === m_sd[k], "R5 R6 stage tag",
          {28'd0, stage_vld[k], stage_dst[k*3+:3]}, {28'd0, m_sv[k], m_sd[k]});
    if (!stall_n) run_len++; else run_len = 0;
    if (run_len > max_run) max_run = run_len;
    @(posedge clk);
    if (rst) begin
      m_dv = 0; m_da = 0; m_db = 0; m_dd = 0;
      for (int k = 0; k < 3; k++) begin m_sv[k] = 0; m_sd[k] = 0; end
    end else begin
      m_sv[2] = m_sv[1]; m_sd[2] = m_sd[1];
      m_sv[1] = m_sv[0]; m_sd[1] = m_sd[0];
      m_sv[0] = m_dv && !e;
      m_sd[0] = (m_dv && !e) ? m_dd : 3'd0;
      if (!e) begin
        m_dv = fetch_vld; m_da = fetch_src_a; m_db = fetch_src_b; m_dd = fetch_dst;
      end
    end
    @(negedge clk);
  endtask

  // present an instruction until accepted; held = cycles it waited
  task automatic issue(bit v, bit [2:0] a, bit [2:0] b, bit [2:0] d, bit garb, output int held);
    bit h;
    fetch_vld = v; fetch_src_a = a; fetch_src_b = b; fetch_dst = d;
    held = 0;
    forever begin
      h = fetch_hold;
      tick();
      if (!h) break;
      held++;
      if (garb) begin
        fetch_vld = 1'b1; fetch_src_a = 3'($urandom % 8);
        fetch_src_b = 3'($urandom % 8); fetch_dst = 3'($urandom % 8);
      end
    end
  endtask

  task automatic drain();
    int h;
    for (int i = 0; i < 4; i++) issue(1, 0, 0, 0, 0, h);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int h;
    void'($urandom(1234));
    rst = 1; fetch_vld = 1; fetch_src_a = 3; fetch_src_b = 5; fetch_dst = 3;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();
    rst = 0;
    // R1: reset state
    chk(stall_n === 1'b1 && stage_vld === 3'b000 && stage_dst === 9'd0, "R1 reset state",
        {22'd0, stall_n, stage_vld, stage_dst}, {22'd0, 1'b1, 12'd0});

    // R7: back-to-back dependency, three stalls
    drain();
    issue(1, 0, 0, 5, 0, h);
    issue(1, 5, 0, 1, 0, h);
    chk(h == 0, "R7 producer-consumer accepted", h, 0);
    issue(1, 0, 0, 0, 0, h);
    chk(h == 3, "R7 adjacent stall count", h, 3);
    chk(stage_vld[0] === 1'b1 && stage_dst[2:0] === 3'd1, "R7 consumer in execute",
        {28'd0, stage_vld[0], stage_dst[2:0]}, {28'd0, 1'b1, 3'd1});

    // R8: distances 2, 3, 4
    for (int d = 2; d <= 4; d++) begin
      drain();
      issue(1, 0, 0, 3, 0, h);
      for (int n = 0; n < d - 1; n++) issue(1, 0, 0, 0, 0, h);
      issue(1, 6, 3, 2, 0, h);
      issue(1, 0, 0, 0, 0, h);
      chk(h == 4 - d, "R8 stall count by distance", h, 4 - d);
    end

    // R3: destination 0 and sources 0
    drain();
    issue(1, 0, 0, 0, 0, h);
    issue(1, 0, 0, 4, 0, h);
    issue(1, 0, 0, 2, 0, h);
    issue(1, 0, 0, 0, 0, h);
    chk(h == 0, "R3 register 0 never stalls", h, 0);

    // R10: empty slot with matching sources
    drain();
    issue(1, 0, 0, 6, 0, h);
    issue(0, 6, 6, 6, 0, h);
    issue(1, 0, 0, 0, 0, h);
    chk(h == 0, "R10 empty slot no stall", h, 0);
    chk(stage_vld[0] === 1'b0 && stage_dst[2:0] === 3'd0, "R10 empty slot enters as bubble",
        {28'd0, stage_vld[0], stage_dst[2:0]}, 0);

    // R4: fetch inputs scrambled while held are ignored
    drain();
    issue(1, 0, 0, 7, 0, h);
    issue(1, 7, 0, 2, 0, h);
    issue(1, 0, 0, 0, 1, h);
    chk(h == 3, "R4 stall count with scrambled fetch", h, 3);
    chk(stage_vld[0] === 1'b1 && stage_dst[2:0] === 3'd2, "R4 held instruction enters execute",
        {28'd0, stage_vld[0], stage_dst[2:0]}, {28'd0, 1'b1, 3'd2});

    // random mix
    drain();
    for (int i = 0; i < 400; i++)
      issue(($urandom % 10) != 0, 3'($urandom % 8), 3'($urandom % 8), 3'($urandom % 8), 0, h);
    drain();

    chk(max_run <= 3, "R9 longest stall run", max_run, 3);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule